// File: doc/BRIEF.md
# Accumulator Middle-Word Logical Shifter

This block is one execution slice of a DSP datapath. It holds two 56-bit accumulators, A and B. Each is split into an 8-bit extension (bits 55..48), a 24-bit middle word (bits 47..24) and a 24-bit low word (bits 23..0). When an operation is accepted, the block shifts the middle word of the chosen accumulator right by one bit and fills bit 47 with zero. The extension and low words stay as they are. The block also updates five flags in a 16-bit status word.

Operations enter through a valid/ready pair. An operation is accepted on a rising edge where `op_valid` and `op_ready` are both high. After that edge, `op_ready` is low for one cycle, so no back-pressure is held longer than that. A request seen while `op_ready` is low is dropped, not queued. The result is written at the next edge, and `done` pulses for the single cycle that follows. The whole operation therefore takes two cycles.

Load ports preset the accumulators and the status word. Read ports show their current values. A single input, `op_limit`, stands in for a limiting event during the accompanying data move. It is sampled together with the accepted request.

Top module: `acc_mid_shifter`

## Requirements
- R1: A synchronous active-high `rst` clears both accumulators and the status word to zero. The cycle after reset, `op_ready` is 1 and `done` is 0.
- R2: When `ld_a_en`, `ld_b_en` or `ld_sr_en` is high at an edge, the matching register takes `ld_a_val`, `ld_b_val` or `ld_sr_val` at that edge. The new value shows on the read port in the next cycle.
- R3: An accepted operation replaces bits 47..24 of the destination with those bits shifted right by one position toward bit 24, with a zero entering bit 47.
- R4: Bits 55..48 and bits 23..0 of the destination keep their values through the operation.
- R5: Status bit 0 (carry) takes the value that destination bit 24 had before the shift.
- R6: Status bit 2 (zero) is 1 when the new bits 47..24 are all zero, and 0 otherwise.
- R7: Status bit 1 (overflow) and bit 3 (negative) are cleared. Status bits 4, 5 and 7..15 keep their values.
- R8: Status bit 6 (limit) is set when `op_limit` was high with the accepted request. Otherwise it keeps its prior value, so it is sticky.
- R9: `op_dest` = 0 selects accumulator A and `op_dest` = 1 selects accumulator B. The other accumulator is not changed by the operation.
- R10: The result is written at the second edge after the accepting edge. `op_ready` is 0 and `done` is 0 in the cycle between the two edges. `done` is 1 for exactly the one cycle after the write, and `op_ready` is 1 again in that cycle.
- R11: A request presented while `op_ready` is 0 is ignored. It produces no write and no `done`.
- R12: At the write edge, the operation result overrides a simultaneous load of the destination accumulator or of the status word. The operand is the destination value held during the cycle just before the write.
- R13: The write also refreshes the whole status word, which is an extension of R12. A status load in that same edge is therefore lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Shift request valid |
| op_ready | output | 1 | Block can accept a request |
| op_dest | input | 1 | Destination select: 0 = A, 1 = B |
| op_limit | input | 1 | Limiting event with this request |
| done | output | 1 | One-cycle pulse after the result is written |
| ld_a_en | input | 1 | Load accumulator A |
| ld_a_val | input | 56 | Load value for A |
| ld_b_en | input | 1 | Load accumulator B |
| ld_b_val | input | 56 | Load value for B |
| ld_sr_en | input | 1 | Load status word |
| ld_sr_val | input | 16 | Load value for status word |
| acc_a | output | 56 | Accumulator A contents |
| acc_b | output | 56 | Accumulator B contents |
| sr | output | 16 | Status word contents |

## Verification
The bound checker examines every `done` cycle against the cycle before it. In that cycle it checks the following:
- the shifted middle word and the zero in bit 47;
- the untouched extension and low words;
- carry taken from the old bit 24;
- the zero flag against the new middle word;
- negative and overflow both clear;
- limit stickiness;
- the other accumulator left unchanged;
- the ready and done handshake timing.

Only the bench's scenarios can show three further behaviours. These are a limit event being captured from the request cycle, a second request during the busy cycle being dropped, and a load colliding with the write edge. The bench's reference model is compared against all outputs on every clock.

// File: rtl/acc_shift_pkg.sv
package acc_shift_pkg;
  // Status word flag positions
  localparam int unsigned FLG_C = 0;
  localparam int unsigned FLG_V = 1;
  localparam int unsigned FLG_Z = 2;
  localparam int unsigned FLG_N = 3;
  localparam int unsigned FLG_L = 6;

  typedef enum logic {
    SEL_A = 1'b0,
    SEL_B = 1'b1
  } acc_sel_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_EXEC = 1'b1
  } phase_e;

  typedef struct packed {
    acc_sel_e dest;
    logic     lim;
  } op_ctx_t;
endpackage

// File: rtl/op_sequencer.sv
module op_sequencer
  import acc_shift_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     op_valid,
  input  logic     op_dest,
  input  logic     op_limit,
  output logic     op_ready,
  output logic     commit,
  output logic     done,
  output op_ctx_t  ctx_q
);
  phase_e phase_q;
  logic   accept;

  assign op_ready = (phase_q == PH_IDLE);
  assign accept   = op_valid && op_ready;
  assign commit   = (phase_q == PH_EXEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      done       <= 1'b0;
      ctx_q.dest <= SEL_A;
      ctx_q.lim  <= 1'b0;
    end else begin
      done <= commit;
      if (accept) begin
        phase_q    <= PH_EXEC;
        ctx_q.dest <= acc_sel_e'(op_dest);
        ctx_q.lim  <= op_limit;
      end else begin
        phase_q <= PH_IDLE;
      end
    end
  end
endmodule

// File: rtl/shift_core.sv
module shift_core
  import acc_shift_pkg::*;
#(
  parameter int unsigned EXT_W = 8,
  parameter int unsigned MID_W = 24,
  parameter int unsigned LOW_W = 24,
  parameter int unsigned SR_W  = 16,
  localparam int unsigned ACC_W = EXT_W + MID_W + LOW_W
) (
  input  logic [ACC_W-1:0] acc_in,
  input  logic [SR_W-1:0]  sr_in,
  input  logic             lim,
  output logic [ACC_W-1:0] acc_out,
  output logic [SR_W-1:0]  sr_out
);
  localparam int unsigned MID_LO = LOW_W;
  localparam int unsigned MID_HI = LOW_W + MID_W - 1;

  logic [MID_W-1:0] mid_in;
  logic [MID_W-1:0] mid_out;

  assign mid_in  = acc_in[MID_HI:MID_LO];
  assign mid_out = {1'b0, mid_in[MID_W-1:1]};

  always_comb begin
    acc_out                = acc_in;
    acc_out[MID_HI:MID_LO] = mid_out;
    sr_out                 = sr_in;
    sr_out[FLG_C]          = mid_in[0];
    sr_out[FLG_V]          = 1'b0;
    sr_out[FLG_Z]          = (mid_out == '0);
    sr_out[FLG_N]          = 1'b0;
    sr_out[FLG_L]          = sr_in[FLG_L] | lim;
  end
endmodule

// File: rtl/acc_file.sv
module acc_file #(
  parameter int unsigned ACC_W = 56,
  parameter int unsigned N_ACC = 2,
  localparam int unsigned SEL_W = (N_ACC > 1) ? $clog2(N_ACC) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_ACC-1:0]            ld_en,
  input  logic [N_ACC-1:0][ACC_W-1:0] ld_data,
  input  logic                        wr_en,
  input  logic [SEL_W-1:0]            wr_sel,
  input  logic [ACC_W-1:0]            wr_data,
  input  logic [SEL_W-1:0]            rd_sel,
  output logic [ACC_W-1:0]            rd_data,
  output logic [N_ACC-1:0][ACC_W-1:0] acc_q
);
  for (genvar i = 0; i < N_ACC; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst)
        acc_q[i] <= '0;
      else if (wr_en && (wr_sel == SEL_W'(i)))
        acc_q[i] <= wr_data;
      else if (ld_en[i])
        acc_q[i] <= ld_data[i];
    end
  end

  assign rd_data = acc_q[rd_sel];
endmodule

// File: rtl/status_reg.sv
module status_reg #(
  parameter int unsigned SR_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld_en,
  input  logic [SR_W-1:0] ld_val,
  input  logic            wr_en,
  input  logic [SR_W-1:0] wr_val,
  output logic [SR_W-1:0] sr_q
);
  always_ff @(posedge clk) begin
    if (rst)        sr_q <= '0;
    else if (wr_en) sr_q <= wr_val;
    else if (ld_en) sr_q <= ld_val;
  end
endmodule

// File: rtl/acc_mid_shifter.sv
module acc_mid_shifter
  import acc_shift_pkg::*;
#(
  parameter int unsigned EXT_W = 8,
  parameter int unsigned MID_W = 24,
  parameter int unsigned LOW_W = 24,
  parameter int unsigned SR_W  = 16,
  localparam int unsigned ACC_W = EXT_W + MID_W + LOW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  output logic             op_ready,
  input  logic             op_dest,
  input  logic             op_limit,
  output logic             done,
  input  logic             ld_a_en,
  input  logic [ACC_W-1:0] ld_a_val,
  input  logic             ld_b_en,
  input  logic [ACC_W-1:0] ld_b_val,
  input  logic             ld_sr_en,
  input  logic [SR_W-1:0]  ld_sr_val,
  output logic [ACC_W-1:0] acc_a,
  output logic [ACC_W-1:0] acc_b,
  output logic [SR_W-1:0]  sr
);
  localparam int unsigned N_ACC = 2;

  op_ctx_t                     ctx_q;
  acc_sel_e                    dest_q;
  logic                        commit;
  logic [ACC_W-1:0]            operand;
  logic [ACC_W-1:0]            result;
  logic [SR_W-1:0]             sr_next;
  logic [N_ACC-1:0][ACC_W-1:0] acc_q;

  assign dest_q = ctx_q.dest;

  op_sequencer u_seq (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_dest  (op_dest),
    .op_limit (op_limit),
    .op_ready (op_ready),
    .commit   (commit),
    .done     (done),
    .ctx_q    (ctx_q)
  );

  acc_file #(.ACC_W(ACC_W), .N_ACC(N_ACC)) u_accs (
    .clk     (clk),
    .rst     (rst),
    .ld_en   ({ld_b_en, ld_a_en}),
    .ld_data ({ld_b_val, ld_a_val}),
    .wr_en   (commit),
    .wr_sel  (dest_q),
    .wr_data (result),
    .rd_sel  (dest_q),
    .rd_data (operand),
    .acc_q   (acc_q)
  );

  shift_core #(.EXT_W(EXT_W), .MID_W(MID_W), .LOW_W(LOW_W), .SR_W(SR_W)) u_core (
    .acc_in  (operand),
    .sr_in   (sr),
    .lim     (ctx_q.lim),
    .acc_out (result),
    .sr_out  (sr_next)
  );

  status_reg #(.SR_W(SR_W)) u_sr (
    .clk    (clk),
    .rst    (rst),
    .ld_en  (ld_sr_en),
    .ld_val (ld_sr_val),
    .wr_en  (commit),
    .wr_val (sr_next),
    .sr_q   (sr)
  );

  assign acc_a = acc_q[0];
  assign acc_b = acc_q[1];
endmodule

// File: rtl/acc_mid_shifter_chk.sv
module acc_mid_shifter_chk
  import acc_shift_pkg::*;
#(
  parameter int unsigned EXT_W = 8,
  parameter int unsigned MID_W = 24,
  parameter int unsigned LOW_W = 24,
  parameter int unsigned SR_W  = 16,
  localparam int unsigned ACC_W = EXT_W + MID_W + LOW_W
) (
  input logic             clk,
  input logic             rst,
  input logic             op_valid,
  input logic             op_ready,
  input logic             done,
  input logic             dest_q,
  input logic             ld_a_en,
  input logic             ld_b_en,
  input logic [ACC_W-1:0] acc_a,
  input logic [ACC_W-1:0] acc_b,
  input logic [SR_W-1:0]  sr
);
  localparam int unsigned MID_LO = LOW_W;
  localparam int unsigned MID_HI = LOW_W + MID_W - 1;

  logic [ACC_W-1:0] sel_acc;
  logic [ACC_W-1:0] oth_acc;
  logic             oth_ld;

  assign sel_acc = dest_q ? acc_b : acc_a;
  assign oth_acc = dest_q ? acc_a : acc_b;
  assign oth_ld  = dest_q ? ld_a_en : ld_b_en;

  assert_mid_shift_R3: assert property (@(posedge clk) disable iff (rst)
    done |-> sel_acc[MID_HI:MID_LO] == ($past(sel_acc[MID_HI:MID_LO]) >> 1));

  assert_edges_kept_R4: assert property (@(posedge clk) disable iff (rst)
    done |-> (sel_acc[ACC_W-1:MID_HI+1] == $past(sel_acc[ACC_W-1:MID_HI+1]))
          && (sel_acc[MID_LO-1:0] == $past(sel_acc[MID_LO-1:0])));

  assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
    done |-> sr[FLG_C] == $past(sel_acc[MID_LO]));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    done |-> sr[FLG_Z] == (sel_acc[MID_HI:MID_LO] == '0));

  assert_nv_clear_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !sr[FLG_N] && !sr[FLG_V]);

  assert_limit_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done && $past(sr[FLG_L]) |-> sr[FLG_L]);

  assert_other_untouched_R9: assert property (@(posedge clk) disable iff (rst)
    done && !$past(oth_ld) |-> oth_acc == $past(oth_acc));

  assert_busy_after_accept_R10: assert property (@(posedge clk) disable iff (rst)
    op_valid && op_ready |=> !op_ready && !done);

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_busy_one_cycle_R11: assert property (@(posedge clk) disable iff (rst)
    !op_ready |=> op_ready && done);
endmodule

bind acc_mid_shifter acc_mid_shifter_chk #(
  .EXT_W(EXT_W), .MID_W(MID_W), .LOW_W(LOW_W), .SR_W(SR_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .op_valid (op_valid),
  .op_ready (op_ready),
  .done     (done),
  .dest_q   (dest_q),
  .ld_a_en  (ld_a_en),
  .ld_b_en  (ld_b_en),
  .acc_a    (acc_a),
  .acc_b    (acc_b),
  .sr       (sr)
);

// File: tb/sim_acc_mid_shifter.sv
`timescale 1ns/1ps
module sim_acc_mid_shifter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0, op_dest = 1'b0, op_limit = 1'b0;
  logic        op_ready, done;
  logic        ld_a_en = 1'b0, ld_b_en = 1'b0, ld_sr_en = 1'b0;
  logic [55:0] ld_a_val = '0, ld_b_val = '0;
  logic [15:0] ld_sr_val = '0;
  logic [55:0] acc_a, acc_b;
  logic [15:0] sr;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  acc_mid_shifter u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_dest(op_dest), .op_limit(op_limit), .done(done),
    .ld_a_en(ld_a_en), .ld_a_val(ld_a_val), .ld_b_en(ld_b_en), .ld_b_val(ld_b_val),
    .ld_sr_en(ld_sr_en), .ld_sr_val(ld_sr_val),
    .acc_a(acc_a), .acc_b(acc_b), .sr(sr)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [55:0] m_a, m_b;
  logic [15:0] m_sr;
  bit          m_busy, m_done, m_dest, m_lim;

  always @(posedge clk) begin
    logic [55:0] opnd, res;
    logic [15:0] nsr;
    if (rst) begin
      m_a = '0; m_b = '0; m_sr = '0;
      m_busy = 0; m_done = 0; m_dest = 0; m_lim = 0;
    end else begin
      opnd = m_dest ? m_b : m_a;
      res = opnd;
      res[47:24] = opnd[47:24] >> 1;
      nsr = m_sr;
      nsr[0] = opnd[24];
      nsr[1] = 1'b0;
      nsr[2] = (res[47:24] == 24'd0);
      nsr[3] = 1'b0;
      if (m_lim) nsr[6] = 1'b1;
      if (ld_a_en)  m_a  = ld_a_val;
      if (ld_b_en)  m_b  = ld_b_val;
      if (ld_sr_en) m_sr = ld_sr_val;
      if (m_busy) begin
        if (m_dest) m_b = res; else m_a = res;
        m_sr = nsr;
      end
      m_done = m_busy;
      if (op_valid && !m_busy) begin
        m_busy = 1; m_dest = op_dest; m_lim = op_limit;
      end else begin
        m_busy = 0;
      end
    end
  end

  // Lockstep comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk("R3 lockstep acc_a", {8'd0, acc_a}, {8'd0, m_a});
      chk("R9 lockstep acc_b", {8'd0, acc_b}, {8'd0, m_b});
      chk("R7 lockstep sr", {48'd0, sr}, {48'd0, m_sr});
      chk("R10 lockstep ready", {63'd0, op_ready}, {63'd0, !m_busy});
      chk("R10 lockstep done", {63'd0, done}, {63'd0, m_done});
    end
  end

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic load(input bit ea, input logic [55:0] va, input bit eb,
                      input logic [55:0] vb, input bit es, input logic [15:0] vs);
    ld_a_en = ea; ld_a_val = va; ld_b_en = eb; ld_b_val = vb; ld_sr_en = es; ld_sr_val = vs;
    cyc();
    ld_a_en = 0; ld_b_en = 0; ld_sr_en = 0;
  endtask

  // Issues a request, checks the busy cycle, returns in the done cycle
  task automatic run_op(input bit dest, input bit lim);
    op_valid = 1; op_dest = dest; op_limit = lim;
    cyc();
    op_valid = 0; op_limit = 0;
    chk("R10 busy ready", {63'd0, op_ready}, 64'd0);
    chk("R10 busy done", {63'd0, done}, 64'd0);
    cyc();
    chk("R10 done pulse", {63'd0, done}, 64'd1);
    chk("R10 ready back", {63'd0, op_ready}, 64'd1);
  endtask

  initial begin
    repeat (3) cyc();
    rst = 0;
    cyc();
    // R1 reset state
    chk("R1 acc_a", {8'd0, acc_a}, 64'd0);
    chk("R1 acc_b", {8'd0, acc_b}, 64'd0);
    chk("R1 sr", {48'd0, sr}, 64'd0);
    chk("R1 ready", {63'd0, op_ready}, 64'd1);
    chk("R1 done", {63'd0, done}, 64'd0);

    // R2 loads
    load(1, 56'h37_444445_828180, 1, 56'hFF_000001_ABCDEF, 1, 16'h0300);
    chk("R2 acc_a", {8'd0, acc_a}, {8'd0, 56'h37_444445_828180});
    chk("R2 acc_b", {8'd0, acc_b}, {8'd0, 56'hFF_000001_ABCDEF});
    chk("R2 sr", {48'd0, sr}, 64'h0300);

    // R3 R4 R5 on A, example values
    run_op(0, 0);
    chk("R3 R4 acc_a", {8'd0, acc_a}, {8'd0, 56'h37_222222_828180});
    chk("R5 sr", {48'd0, sr}, 64'h0301);
    chk("R9 acc_b kept", {8'd0, acc_b}, {8'd0, 56'hFF_000001_ABCDEF});

    // R6 R7 R9 on B with all flags preset
    load(0, '0, 0, '0, 1, 16'hFFFF);
    run_op(1, 0);
    chk("R9 acc_b", {8'd0, acc_b}, {8'd0, 56'hFF_000000_ABCDEF});
    chk("R6 R7 sr", {48'd0, sr}, 64'hFFF5);
    chk("R9 acc_a kept", {8'd0, acc_a}, {8'd0, 56'h37_222222_828180});

    // R8 limit set then sticky
    load(1, 56'h00_800000_000000, 0, '0, 1, 16'h0000);
    run_op(0, 1);
    chk("R8 acc_a", {8'd0, acc_a}, {8'd0, 56'h00_400000_000000});
    chk("R8 limit set", {48'd0, sr}, 64'h0040);
    run_op(0, 0);
    chk("R8 limit sticky", {48'd0, sr}, 64'h0040);

    // R11 request during busy cycle is dropped
    load(0, '0, 1, 56'h12_000003_345678, 0, '0);
    op_valid = 1; op_dest = 1;
    cyc();
    cyc();            // second request presented while not ready
    op_valid = 0;
    chk("R11 one shift", {8'd0, acc_b}, {8'd0, 56'h12_000001_345678});
    cyc();
    chk("R11 no second done", {63'd0, done}, 64'd0);
    chk("R11 acc_b after", {8'd0, acc_b}, {8'd0, 56'h12_000001_345678});

    // R12 R13 collision at the write edge
    load(1, 56'hAA_000002_111111, 0, '0, 1, 16'h0000);
    op_valid = 1; op_dest = 0;
    cyc();
    op_valid = 0;
    ld_a_en = 1; ld_a_val = 56'h55_FFFFFF_222222;
    ld_sr_en = 1; ld_sr_val = 16'hFFFF;
    cyc();
    ld_a_en = 0; ld_sr_en = 0;
    chk("R12 acc_a", {8'd0, acc_a}, {8'd0, 56'hAA_000001_111111});
    chk("R13 sr", {48'd0, sr}, 64'h0000);

    cyc();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R10: got hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule